// File: doc/BRIEF.md
# Phase-Bit Reply Ring Consumer

This block takes completion entries out of a circular reply ring that a storage controller fills in local memory. Each ring slot holds one 64-bit entry. The block keeps its own head index and an expected phase bit. It never reads a producer index. A slot counts as fresh only when bit 0 of the stored entry equals the expected phase. The producer inverts that bit each time it laps the ring, so entries left over from the previous lap are stale by construction.

A fetch is requested with a valid/ready handshake. In legacy (wired) interrupt mode, each fetch first writes the clear value to the outbound doorbell clear register and then reads the doorbell status register back, which flushes the write. Only after that does it read the head slot. When message-signalled interrupts are used, both register accesses are skipped. The result comes back as a one-cycle pulse:
- A fresh entry returns the entry itself. The head then advances, and an outstanding-command counter goes down by one.
- A stale slot returns the all-ones empty code, and the head stays where it is.

When the head passes the last slot, it returns to 0 and the expected phase inverts. A separate post pulse counts commands handed to the controller. An interrupt-pending output combines the controller's status register value with the doorbell status bit.

The fetch sequencer has six states:
- `ST_IDLE`: ready for a request.
- `ST_DB_CLEAR`: writes the doorbell clear register and waits for its acknowledge.
- `ST_DB_FLUSH`: reads the doorbell status register and waits for its acknowledge.
- `ST_MEM_ISSUE`: issues the one-cycle slot read.
- `ST_MEM_WAIT`: waits for the read data.
- `ST_DELIVER`: presents the result.

Its transitions are:
- accept-legacy: `ST_IDLE`→`ST_DB_CLEAR`
- accept-msi: `ST_IDLE`→`ST_MEM_ISSUE`
- clear-acked: `ST_DB_CLEAR`→`ST_DB_FLUSH`
- flush-acked: `ST_DB_FLUSH`→`ST_MEM_ISSUE`
- read-issued: `ST_MEM_ISSUE`→`ST_MEM_WAIT`
- data-returned: `ST_MEM_WAIT`→`ST_DELIVER`
- delivered: `ST_DELIVER`→`ST_IDLE`

Top module: `ring_reply_consumer`

## Requirements
- R1: A slot is fresh when bit 0 of its entry equals `ring_phase`. The `result_hit` output is 1 for a fresh slot and 0 for a stale one, and a fresh result carries the stored entry unchanged.
- R2: A stale slot returns `result_data` equal to all ones, and `ring_head`, `ring_phase` and `outstanding` keep their values.
- R3: A fresh slot advances `ring_head` by one and lowers `outstanding` by one. If `outstanding` is already 0 it stays at 0.
- R4: When a fresh slot is taken from index RING_DEPTH-1, `ring_head` returns to 0 and `ring_phase` inverts. `ring_head` is always below RING_DEPTH.
- R5: In legacy mode (`msi_mode`=0 when the request is accepted), the block first writes 0x00000001 to register address 0xA0 and waits for `reg_ack`. It then reads register address 0x9C and waits for `reg_ack`. Only then does it issue the slot read. Exactly these two accesses occur per fetch.
- R6: In MSI mode (`msi_mode`=1 when the request is accepted), no register access occurs, and `mem_req` is raised in the cycle after the request is accepted.
- R7: `irq_pending` is 1 exactly when `intr_status` is non-zero and either `msi_mode` is 1 or `db_status_bit` is 1.
- R8: `result_valid` is a one-cycle pulse, asserted in the cycle after the one in which `mem_rvalid` is high. `fetch_ready` is 1 only while idle.
- R9: After reset, `ring_head` is 0, `ring_phase` is 1, `outstanding` is 0, `fetch_ready` is 1 and `result_valid` is 0.
- R10: A `cmd_post` pulse raises `outstanding` by one, saturating at RING_DEPTH. A post in the same cycle as a fresh-slot consume leaves `outstanding` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_mode | input | 1 | 1 when message-signalled interrupts are in use |
| fetch_valid | input | 1 | Fetch request |
| fetch_ready | output | 1 | Fetch request accepted when high with fetch_valid |
| result_valid | output | 1 | One-cycle result strobe |
| result_hit | output | 1 | 1 when the result is a fresh entry |
| result_data | output | ENTRY_W | Entry, or all ones when stale |
| cmd_post | input | 1 | One command handed to the controller |
| outstanding | output | CNT_W | Commands not yet completed |
| ring_head | output | IDX_W | Current head slot |
| ring_phase | output | 1 | Expected phase bit |
| mem_req | output | 1 | Slot read request, one cycle |
| mem_addr | output | IDX_W | Slot index to read |
| mem_rvalid | input | 1 | Slot read data valid |
| mem_rdata | input | ENTRY_W | Slot read data |
| reg_req | output | 1 | Controller register access request, held until acknowledge |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_addr | output | REG_AW | Register address |
| reg_wdata | output | REG_DW | Register write data |
| reg_ack | input | 1 | Register access complete |
| intr_status | input | REG_DW | Controller interrupt status value |
| db_status_bit | input | 1 | Bit 0 of the outbound doorbell status |
| irq_pending | output | 1 | Interrupt pending |

## Verification
The hardest cases to reach from the ports are a stale slot met just after a wrap, when the expected phase has already inverted, and a consume that lands in the same cycle as a new post. The bench produces entries lap after lap with its own phase model and leaves chosen slots unrefreshed across a wrap. It also sweeps memory and register latencies and both interrupt modes. Its memory model raises `cmd_post` in the exact cycle it returns read data, which makes the post and the consume coincide.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DB_CLEAR,
        ST_DB_FLUSH,
        ST_MEM_ISSUE,
        ST_MEM_WAIT,
        ST_DELIVER
    } fetch_state_e;

    // Expected phase after reset: the producer's first lap marks entries with 1.
    localparam logic PHASE_AT_RESET = 1'b1;

endpackage

// File: rtl/ring_head_tracker.sv
module ring_head_tracker #(
    parameter int RING_DEPTH = 8,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] head,
    output logic             phase
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            phase <= ring_pkg::PHASE_AT_RESET;
        end else if (advance) begin
            if (head == LAST_IDX) begin
                head  <= '0;
                phase <= ~phase;
            end else begin
                head  <= head + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ring_outstanding_ctr.sv
module ring_outstanding_ctr #(
    parameter int MAX_COUNT = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_COUNT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (count != TOP) count <= count + 1'b1;
                2'b01:   if (count != '0)  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ring_entry_judge.sv
module ring_entry_judge #(
    parameter int ENTRY_W = 64
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               phase,
    output logic               fresh,
    output logic [ENTRY_W-1:0] shown
);
    always_comb begin
        fresh = (entry[0] == phase);
        shown = fresh ? entry : {ENTRY_W{1'b1}};
    end
endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
    import ring_pkg::*;
#(
    parameter int               REG_AW         = 8,
    parameter int               REG_DW         = 32,
    parameter logic [REG_AW-1:0] DB_CLEAR_ADDR  = 8'hA0,
    parameter logic [REG_AW-1:0] DB_STATUS_ADDR = 8'h9C,
    parameter logic [REG_DW-1:0] DB_CLEAR_VALUE = 32'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic              msi_mode,
    input  logic              reg_ack,
    input  logic              mem_rvalid,
    output logic              fetch_ready,
    output logic              reg_req,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_addr,
    output logic [REG_DW-1:0] reg_wdata,
    output logic              mem_req,
    output logic              capture,
    output logic              deliver
);
    fetch_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (fetch_valid) state_nx = msi_mode ? ST_MEM_ISSUE : ST_DB_CLEAR;
            ST_DB_CLEAR:  if (reg_ack)     state_nx = ST_DB_FLUSH;
            ST_DB_FLUSH:  if (reg_ack)     state_nx = ST_MEM_ISSUE;
            ST_MEM_ISSUE:                  state_nx = ST_MEM_WAIT;
            ST_MEM_WAIT:  if (mem_rvalid)  state_nx = ST_DELIVER;
            ST_DELIVER:                    state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_ready = 1'b0;
        reg_req     = 1'b0;
        reg_we      = 1'b0;
        reg_addr    = '0;
        reg_wdata   = '0;
        mem_req     = 1'b0;
        capture     = 1'b0;
        deliver     = 1'b0;
        unique case (state)
            ST_IDLE:      fetch_ready = 1'b1;
            ST_DB_CLEAR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = DB_CLEAR_ADDR;
                reg_wdata = DB_CLEAR_VALUE;
            end
            ST_DB_FLUSH: begin
                reg_req  = 1'b1;
                reg_addr = DB_STATUS_ADDR;
            end
            ST_MEM_ISSUE: mem_req = 1'b1;
            ST_MEM_WAIT:  capture = mem_rvalid;
            ST_DELIVER:   deliver = 1'b1;
            default:      fetch_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/ring_reply_consumer.sv
module ring_reply_consumer #(
    parameter int               RING_DEPTH     = 8,
    parameter int               ENTRY_W        = 64,
    parameter int               REG_AW         = 8,
    parameter int               REG_DW         = 32,
    parameter logic [REG_AW-1:0] DB_CLEAR_ADDR  = 8'hA0,
    parameter logic [REG_AW-1:0] DB_STATUS_ADDR = 8'h9C,
    parameter logic [REG_DW-1:0] DB_CLEAR_VALUE = 32'h1,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1,
    localparam int CNT_W = $clog2(RING_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_mode,
    input  logic               fetch_valid,
    output logic               fetch_ready,
    output logic               result_valid,
    output logic               result_hit,
    output logic [ENTRY_W-1:0] result_data,
    input  logic               cmd_post,
    output logic [CNT_W-1:0]   outstanding,
    output logic [IDX_W-1:0]   ring_head,
    output logic               ring_phase,
    output logic               mem_req,
    output logic [IDX_W-1:0]   mem_addr,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               reg_req,
    output logic               reg_we,
    output logic [REG_AW-1:0]  reg_addr,
    output logic [REG_DW-1:0]  reg_wdata,
    input  logic               reg_ack,
    input  logic [REG_DW-1:0]  intr_status,
    input  logic               db_status_bit,
    output logic               irq_pending
);
    logic               capture;
    logic               deliver;
    logic               fresh;
    logic               consume;
    logic [ENTRY_W-1:0] shown;
    logic [ENTRY_W-1:0] held_data;
    logic               held_hit;

    ring_fetch_fsm #(
        .REG_AW         (REG_AW),
        .REG_DW         (REG_DW),
        .DB_CLEAR_ADDR  (DB_CLEAR_ADDR),
        .DB_STATUS_ADDR (DB_STATUS_ADDR),
        .DB_CLEAR_VALUE (DB_CLEAR_VALUE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .msi_mode    (msi_mode),
        .reg_ack     (reg_ack),
        .mem_rvalid  (mem_rvalid),
        .fetch_ready (fetch_ready),
        .reg_req     (reg_req),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .mem_req     (mem_req),
        .capture     (capture),
        .deliver     (deliver)
    );

    ring_entry_judge #(.ENTRY_W(ENTRY_W)) u_judge (
        .entry (mem_rdata),
        .phase (ring_phase),
        .fresh (fresh),
        .shown (shown)
    );

    assign consume = capture & fresh;

    ring_head_tracker #(.RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_head (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (consume),
        .head    (ring_head),
        .phase   (ring_phase)
    );

    ring_outstanding_ctr #(.MAX_COUNT(RING_DEPTH), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cmd_post),
        .dec   (consume),
        .count (outstanding)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_data <= '1;
            held_hit  <= 1'b0;
        end else if (capture) begin
            held_data <= shown;
            held_hit  <= fresh;
        end
    end

    assign mem_addr     = ring_head;
    assign result_valid = deliver;
    assign result_hit   = deliver & held_hit;
    assign result_data  = held_data;
    assign irq_pending  = (|intr_status) & (msi_mode | db_status_bit);
endmodule

// File: rtl/ring_reply_checker.sv
module ring_reply_checker #(
    parameter int               RING_DEPTH     = 8,
    parameter int               ENTRY_W        = 64,
    parameter int               REG_AW         = 8,
    parameter int               REG_DW         = 32,
    parameter logic [REG_AW-1:0] DB_CLEAR_ADDR  = 8'hA0,
    parameter logic [REG_AW-1:0] DB_STATUS_ADDR = 8'h9C,
    parameter logic [REG_DW-1:0] DB_CLEAR_VALUE = 32'h1,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1,
    localparam int CNT_W = $clog2(RING_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msi_mode,
    input logic               fetch_valid,
    input logic               fetch_ready,
    input logic               result_valid,
    input logic               result_hit,
    input logic [ENTRY_W-1:0] result_data,
    input logic [CNT_W-1:0]   outstanding,
    input logic [IDX_W-1:0]   ring_head,
    input logic               ring_phase,
    input logic               mem_req,
    input logic               mem_rvalid,
    input logic               reg_req,
    input logic               reg_we,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [REG_DW-1:0]  reg_wdata,
    input logic               reg_ack
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

    AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && result_hit |-> result_data[0] == $past(ring_phase)); // R1
    AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !result_hit |-> result_data == {ENTRY_W{1'b1}}); // R2
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !result_hit |-> $stable(ring_head) && $stable(ring_phase)); // R2
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && result_hit |->
            ring_head == (($past(ring_head) == LAST_IDX) ? '0 : $past(ring_head) + 1'b1)); // R3
    AST_WRAP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && result_hit && ring_head == '0 |-> ring_phase != $past(ring_phase)); // R4
    AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ring_head <= LAST_IDX); // R4
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_we |-> reg_addr == DB_CLEAR_ADDR && reg_wdata == DB_CLEAR_VALUE); // R5
    AST_FLUSH_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_we && !$past(reg_req && !reg_we) |->
            $past(reg_req && reg_we && reg_ack) && reg_addr == DB_STATUS_ADDR); // R5
    AST_MSI_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_ready && msi_mode |=> mem_req && !reg_req); // R6
    AST_RESULT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(mem_rvalid)); // R8
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> !fetch_ready); // R8
    AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CNT_W'(RING_DEPTH)); // R10
endmodule

bind ring_reply_consumer ring_reply_checker #(
    .RING_DEPTH     (RING_DEPTH),
    .ENTRY_W        (ENTRY_W),
    .REG_AW         (REG_AW),
    .REG_DW         (REG_DW),
    .DB_CLEAR_ADDR  (DB_CLEAR_ADDR),
    .DB_STATUS_ADDR (DB_STATUS_ADDR),
    .DB_CLEAR_VALUE (DB_CLEAR_VALUE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msi_mode     (msi_mode),
    .fetch_valid  (fetch_valid),
    .fetch_ready  (fetch_ready),
    .result_valid (result_valid),
    .result_hit   (result_hit),
    .result_data  (result_data),
    .outstanding  (outstanding),
    .ring_head    (ring_head),
    .ring_phase   (ring_phase),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .reg_req      (reg_req),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_ack      (reg_ack)
);

// File: tb/tb_ring_reply_consumer.sv
`timescale 1ns/1ps
module tb_ring_reply_consumer;
    localparam int DEPTH = 4;
    localparam int IW    = 2;
    localparam int CW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msi_mode = 1'b0;
    logic          fetch_valid = 1'b0;
    logic          fetch_ready;
    logic          result_valid;
    logic          result_hit;
    logic [63:0]   result_data;
    logic          post_manual = 1'b0;
    logic          post_auto = 1'b0;
    logic          cmd_post;
    logic [CW-1:0] outstanding;
    logic [IW-1:0] ring_head;
    logic          ring_phase;
    logic          mem_req;
    logic [IW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          reg_req;
    logic          reg_we;
    logic [7:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic          reg_ack = 1'b0;
    logic [31:0]   intr_status = '0;
    logic          db_status_bit = 1'b0;
    logic          irq_pending;

    assign cmd_post = post_manual | post_auto;

    always #2 clk = ~clk;

    ring_reply_consumer #(.RING_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .result_valid(result_valid), .result_hit(result_hit), .result_data(result_data),
        .cmd_post(cmd_post), .outstanding(outstanding),
        .ring_head(ring_head), .ring_phase(ring_phase),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .intr_status(intr_status), .db_status_bit(db_status_bit),
        .irq_pending(irq_pending)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rv_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // ring memory model with programmable latency
    logic [63:0] ring_mem [0:DEPTH-1];
    int          mem_lat = 0;
    int          mem_cnt = 0;
    logic        mem_busy = 1'b0;
    logic [IW-1:0] mem_a = '0;
    logic        post_on_return = 1'b0;

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        post_auto  <= 1'b0;
        if (mem_busy) begin
            if (mem_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= ring_mem[mem_a];
                mem_busy   <= 1'b0;
                rv_cyc     <= cyc;
                if (post_on_return) post_auto <= 1'b1;
            end else begin
                mem_cnt <= mem_cnt - 1;
            end
        end else if (mem_req) begin
            mem_busy <= 1'b1;
            mem_a    <= mem_addr;
            mem_cnt  <= mem_lat;
        end
    end

    // register target model with acknowledge latency and access log
    int          reg_lat = 0;
    int          reg_cnt = 0;
    logic        reg_busy = 1'b0;
    int          reg_n = 0;
    logic        log_we   [0:511];
    logic [7:0]  log_addr [0:511];
    logic [31:0] log_wd   [0:511];

    always @(negedge clk) begin
        reg_ack <= 1'b0;
        if (reg_busy) begin
            if (reg_cnt == 0) begin
                reg_ack  <= 1'b1;
                reg_busy <= 1'b0;
            end else begin
                reg_cnt <= reg_cnt - 1;
            end
        end else if (reg_req && !reg_ack) begin
            log_we[reg_n % 512]   <= reg_we;
            log_addr[reg_n % 512] <= reg_addr;
            log_wd[reg_n % 512]   <= reg_wdata;
            reg_n    <= reg_n + 1;
            reg_busy <= 1'b1;
            reg_cnt  <= reg_lat;
        end
    end

    // bench-side models
    int          exp_head = 0;
    logic        exp_phase = 1'b1;
    int          exp_out = 0;
    int          prod_idx = 0;
    logic        prod_phase = 1'b1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic produce(input int tag);
        ring_mem[prod_idx] = {32'hC0DE0000 + 32'(tag), 31'(tag * 7), prod_phase};
        if (prod_idx == DEPTH - 1) begin
            prod_idx   = 0;
            prod_phase = ~prod_phase;
        end else begin
            prod_idx++;
        end
    endtask

    task automatic post_one();
        @(negedge clk); post_manual = 1'b1;
        @(negedge clk); post_manual = 1'b0;
        if (exp_out < DEPTH) exp_out++;
    endtask

    task automatic fetch_and_check(input bit msi, input bit coincide_post);
        int           base;
        logic [63:0]  entry;
        bit           exp_hit;
        entry   = ring_mem[exp_head];
        exp_hit = (entry[0] == exp_phase);
        @(negedge clk);
        msi_mode       = msi;
        post_on_return = coincide_post;
        base           = reg_n;
        fetch_valid    = 1'b1;
        while (!fetch_ready) @(negedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        while (!result_valid) @(negedge clk);
        check(result_hit == exp_hit, "R1 hit flag", 64'(result_hit), 64'(exp_hit));
        check(cyc == rv_cyc + 1, "R8 result latency", 64'(cyc - rv_cyc), 64'd1);
        check(fetch_ready == 1'b0, "R8 ready while busy", 64'(fetch_ready), 64'd0);
        if (exp_hit) begin
            check(result_data == entry, "R1 entry data", result_data, entry);
            if (exp_head == DEPTH - 1) begin
                exp_head  = 0;
                exp_phase = ~exp_phase;
            end else begin
                exp_head++;
            end
            if (!coincide_post && exp_out > 0) exp_out--;
        end else begin
            check(result_data == '1, "R2 empty code", result_data, '1);
            if (coincide_post && exp_out < DEPTH) exp_out++;
        end
        check(int'(ring_head) == exp_head, exp_hit ? "R3 head advance" : "R2 head hold",
              64'(ring_head), 64'(exp_head));
        check(ring_phase == exp_phase, "R4 phase", 64'(ring_phase), 64'(exp_phase));
        check(int'(outstanding) == exp_out, exp_hit ? "R3 outstanding" : "R2 outstanding hold",
              64'(outstanding), 64'(exp_out));
        @(negedge clk);
        check(result_valid == 1'b0, "R8 single pulse", 64'(result_valid), 64'd0);
        post_on_return = 1'b0;
        if (msi) begin
            check(reg_n == base, "R6 no register access", 64'(reg_n - base), 64'd0);
        end else begin
            check(reg_n - base == 2, "R5 access count", 64'(reg_n - base), 64'd2);
            check(log_we[base % 512] == 1'b1 && log_addr[base % 512] == 8'hA0 && log_wd[base % 512] == 32'h1,
                  "R5 clear write", {log_we[base % 512], log_addr[base % 512], log_wd[base % 512]}, {1'b1, 8'hA0, 32'h1});
            check(log_we[(base + 1) % 512] == 1'b0 && log_addr[(base + 1) % 512] == 8'h9C,
                  "R5 status read", {log_we[(base + 1) % 512], log_addr[(base + 1) % 512]}, {1'b0, 8'h9C});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ring_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(ring_head) == 0, "R9 head", 64'(ring_head), 64'd0);
        check(ring_phase == 1'b1, "R9 phase", 64'(ring_phase), 64'd1);
        check(int'(outstanding) == 0, "R9 outstanding", 64'(outstanding), 64'd0);
        check(fetch_ready == 1'b1, "R9 ready", 64'(fetch_ready), 64'd1);
        check(result_valid == 1'b0, "R9 no result", 64'(result_valid), 64'd0);

        // R7 sweep over status value, doorbell bit and mode
        for (int s = 0; s < 3; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [31:0] sv;
                    bit          e;
                    sv = (s == 0) ? 32'h0 : ((s == 1) ? 32'h1 : 32'h8000_0000);
                    @(negedge clk);
                    intr_status = sv; db_status_bit = d[0]; msi_mode = m[0];
                    #1;
                    e = (sv != 0) && (m != 0 || d != 0);
                    check(irq_pending == e, "R7 irq pending", 64'(irq_pending), 64'(e));
                end
            end
        end
        intr_status = '0; db_status_bit = 1'b0;

        // stale ring right after reset, then consume with nothing outstanding
        fetch_and_check(1'b0, 1'b0);
        produce(1);
        fetch_and_check(1'b1, 1'b0);

        // R10 saturation
        for (int i = 0; i < DEPTH + 1; i++) post_one();
        check(int'(outstanding) == DEPTH, "R10 saturate", 64'(outstanding), 64'(DEPTH));

        // R10 post coinciding with consume
        produce(2);
        fetch_and_check(1'b0, 1'b1);

        // sweep: laps, both modes, latencies, gaps that leave stale slots
        for (int k = 0; k < 30; k++) begin
            mem_lat = k % 3;
            reg_lat = (k / 3) % 3;
            if (k % 4 != 3) begin
                produce(100 + k);
                post_one();
            end
            fetch_and_check(k[0], 1'b0);
            if (k % 7 == 5) fetch_and_check(~k[0], 1'b0);
        end

        // stale slot right after a wrap with a fresh phase
        while (prod_idx != 0) begin
            produce(500 + prod_idx);
        end
        while (exp_head != 0) fetch_and_check(1'b1, 1'b0);
        fetch_and_check(1'b0, 1'b0);
        produce(600);
        fetch_and_check(1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule